// File: doc/BRIEF.md
# Init-Window Watchdog Timer

This block is a supervisory timer for a microcontroller-class chip. A 16-bit up-counter starts running as soon as reset is released. A prescaler sets its rate, and software picks a prescale of 2 or 128 system clocks per count. Software keeps the system alive by sending a service strobe. The strobe loads the upper byte of the counter from a programmed reload byte and zeroes the lower byte. If software stops servicing, the counter wraps past its all-ones value. The block then issues a one-cycle internal reset request and drives a low-active reset-out indication.

Start-up code may switch the timer off, but only while the initialization window is still open. The window closes on the end-of-initialization strobe. From then on a disable request has no effect. The reset-out indication is low after any reset, including one caused by the watchdog itself. It returns high only on the next end-of-initialization strobe. A sticky flag records that the most recent reset came from the watchdog, and a clear strobe removes it. Reload byte and prescale writes are staged and only take hold at the next service.

Top module: `init_window_watchdog`

## Requirements
- R1: While and directly after `rstN` is low, `wdtCount` is 0, `resetReq` is 0, `wdtRstFlag` is 0 and `resetOutN` is 0, and the timer is enabled.
- R2: An enabled timer adds one to `wdtCount` every 2 clocks when the active prescale select is 0, and every 128 clocks when it is 1. The prescale restarts on every service.
- R3: Without any service after reset, `resetReq` goes high exactly 131072 clock edges after reset release, and stays high for exactly one cycle.
- R4: A service strobe sets `wdtCount` to {reload byte, 8'h00}. Counting then resumes from that value: with reload 8'hFF and prescale 2, the count reaches 16'hFFFF 510 clocks later and overflows 2 clocks after that.
- R5: A `cfgWr` changes neither `wdtCount` nor the prescale rate until the next service strobe.
- R6: `disableStb` stops the counter (it holds its value) only when it arrives before the end-of-initialization strobe. After that strobe it is ignored.
- R7: On overflow, `wdtCount` becomes 0, `resetOutN` goes low, and the reload byte, the prescale selects and the disable state return to their reset values. The initialization window also reopens.
- R8: `resetOutN` goes high only on the edge that samples `initDoneStb`, and stays low otherwise after any reset.
- R9: If a service strobe and an overflow fall on the same edge, the overflow takes effect and the service is dropped.
- R10: `wdtRstFlag` is set by an overflow and cleared by `flagClr`. When both happen on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| serviceStb | input | 1 | Service (refresh) strobe, one cycle |
| disableStb | input | 1 | Disable request, honoured only before end of initialization |
| initDoneStb | input | 1 | End-of-initialization strobe |
| cfgWr | input | 1 | Write strobe for the staged reload byte and prescale select |
| cfgReload | input | 8 | Reload byte for the upper counter half |
| cfgSlow | input | 1 | Prescale select: 0 = divide by 2, 1 = divide by 128 |
| flagClr | input | 1 | Clears the watchdog-reset flag |
| resetReq | output | 1 | One-cycle internal reset request on overflow |
| resetOutN | output | 1 | Low-active reset-out indication |
| wdtRstFlag | output | 1 | Last reset came from the watchdog |
| wdtCount | output | 16 | Current counter value |

## Verification
The assertions assume that `rstN` is released only after a clock edge has passed while it was low. They also assume that strobes are plain synchronous pulses, sampled once per edge. The counter-step property further relies on the fact that only a service strobe can make the count jump by more than one. The bench drives every input just after a falling edge and holds it for one whole cycle. It pulses `rstN` only between falling edges, and it never asserts a strobe for longer than one sampled cycle unless it deliberately holds it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef struct packed {
    logic wipe;    // overflow: return datapath to reset state
    logic reload;  // service: load counter from staged reload byte
    logic run;     // timer enabled
  } wdtCtrl_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath #(
  parameter int CNT_W    = 16,
  parameter int REL_W    = 8,
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdt_pkg::wdtCtrl_t ctrl,
  input  logic              cfgWr,
  input  logic [REL_W-1:0]  cfgReload,
  input  logic              cfgSlow,
  output logic              tickHit,
  output logic              atMax,
  output logic [CNT_W-1:0]  count
);
  localparam int LOW_W = CNT_W - REL_W;
  localparam int PRE_W = (SLOW_DIV > FAST_DIV) ? $clog2(SLOW_DIV) : $clog2(FAST_DIV);
  localparam logic [PRE_W-1:0] FAST_END = PRE_W'(FAST_DIV - 1);
  localparam logic [PRE_W-1:0] SLOW_END = PRE_W'(SLOW_DIV - 1);

  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic [REL_W-1:0] relPend;
  logic             slowPend;
  logic             slowAct;
  logic [PRE_W-1:0] preEnd;

  assign preEnd  = slowAct ? SLOW_END : FAST_END;
  assign tickHit = (pre == preEnd);
  assign atMax   = &cnt;
  assign count   = cnt;

  // staged configuration, taken over only on service
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relPend  <= '0;
      slowPend <= 1'b0;
    end else if (ctrl.wipe) begin
      relPend  <= '0;
      slowPend <= 1'b0;
    end else if (cfgWr) begin
      relPend  <= cfgReload;
      slowPend <= cfgSlow;
    end
  end

  // prescaler and main counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      pre     <= '0;
      slowAct <= 1'b0;
    end else if (ctrl.wipe) begin
      cnt     <= '0;
      pre     <= '0;
      slowAct <= 1'b0;
    end else if (ctrl.reload) begin
      cnt     <= {relPend, {LOW_W{1'b0}}};
      pre     <= '0;
      slowAct <= slowPend;
    end else if (ctrl.run) begin
      if (tickHit) begin
        pre <= '0;
        cnt <= cnt + CNT_W'(1);
      end else begin
        pre <= pre + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/wdt_control.sv
module wdt_control (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serviceStb,
  input  logic               disableStb,
  input  logic               initDoneStb,
  input  logic               flagClr,
  input  logic               tickHit,
  input  logic               atMax,
  output wdt_pkg::wdtCtrl_t  ctrl,
  output logic               resetReq,
  output logic               resetOutN,
  output logic               wdtRstFlag
);
  logic enabled;
  logic initDone;
  logic overflow;

  assign overflow    = enabled & tickHit & atMax;
  assign ctrl.wipe   = overflow;
  assign ctrl.reload = serviceStb & ~overflow;
  assign ctrl.run    = enabled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabled    <= 1'b1;
      initDone   <= 1'b0;
      resetReq   <= 1'b0;
      resetOutN  <= 1'b0;
      wdtRstFlag <= 1'b0;
    end else begin
      resetReq <= overflow;
      if (overflow) begin
        enabled    <= 1'b1;
        initDone   <= 1'b0;
        resetOutN  <= 1'b0;
        wdtRstFlag <= 1'b1;
      end else begin
        if (disableStb && !initDone) enabled <= 1'b0;
        if (initDoneStb) begin
          initDone  <= 1'b1;
          resetOutN <= 1'b1;
        end
        if (flagClr) wdtRstFlag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/init_window_watchdog.sv
module init_window_watchdog #(
  parameter int CNT_W    = 16,
  parameter int REL_W    = 8,
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serviceStb,
  input  logic             disableStb,
  input  logic             initDoneStb,
  input  logic             cfgWr,
  input  logic [REL_W-1:0] cfgReload,
  input  logic             cfgSlow,
  input  logic             flagClr,
  output logic             resetReq,
  output logic             resetOutN,
  output logic             wdtRstFlag,
  output logic [CNT_W-1:0] wdtCount
);
  wdt_pkg::wdtCtrl_t ctrl;
  logic tickHit;
  logic atMax;

  wdt_control u_ctrl (
    .clk(clk), .rstN(rstN), .serviceStb(serviceStb), .disableStb(disableStb),
    .initDoneStb(initDoneStb), .flagClr(flagClr), .tickHit(tickHit), .atMax(atMax),
    .ctrl(ctrl), .resetReq(resetReq), .resetOutN(resetOutN), .wdtRstFlag(wdtRstFlag)
  );

  wdt_datapath #(.CNT_W(CNT_W), .REL_W(REL_W), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .cfgWr(cfgWr), .cfgReload(cfgReload),
    .cfgSlow(cfgSlow), .tickHit(tickHit), .atMax(atMax), .count(wdtCount)
  );
endmodule

// File: rtl/init_window_watchdog_chk.sv
module init_window_watchdog_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             serviceStb,
  input logic             initDoneStb,
  input logic             resetReq,
  input logic             resetOutN,
  input logic             wdtRstFlag,
  input logic [CNT_W-1:0] wdtCount
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq); // R3

  AST_OVF_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (wdtCount == '0) && !resetOutN); // R7

  AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> wdtRstFlag); // R10

  AST_RSTOUT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetOutN) |-> $past(initDoneStb)); // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !resetReq && !$past(serviceStb) && (wdtCount != $past(wdtCount)))
      |-> (wdtCount == $past(wdtCount) + CNT_W'(1))); // R2

  AST_SERVICE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(serviceStb) && !resetReq) |-> (wdtCount[7:0] == 8'h00)); // R4
endmodule

bind init_window_watchdog init_window_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .serviceStb(serviceStb), .initDoneStb(initDoneStb),
  .resetReq(resetReq), .resetOutN(resetOutN), .wdtRstFlag(wdtRstFlag), .wdtCount(wdtCount)
);

// File: tb/test_init_window_watchdog.sv
module test_init_window_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 199000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serviceStb = 1'b0, disableStb = 1'b0, initDoneStb = 1'b0;
  logic cfgWr = 1'b0, cfgSlow = 1'b0, flagClr = 1'b0;
  logic [7:0] cfgReload = 8'h00;
  logic resetReq, resetOutN, wdtRstFlag;
  logic [15:0] wdtCount;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  init_window_watchdog i_init_window_watchdog (
    .clk(clk), .rstN(rstN), .serviceStb(serviceStb), .disableStb(disableStb),
    .initDoneStb(initDoneStb), .cfgWr(cfgWr), .cfgReload(cfgReload), .cfgSlow(cfgSlow),
    .flagClr(flagClr), .resetReq(resetReq), .resetOutN(resetOutN),
    .wdtRstFlag(wdtRstFlag), .wdtCount(wdtCount)
  );

  // reference model built from the requirements
  logic [15:0] mCnt;
  int          mPre;
  logic [7:0]  mRel;
  logic        mSlowPend, mSlowAct, mEn, mDone, mRon, mFlag, mReq;

  function automatic int preEnd(input logic slow);
    return slow ? 127 : 1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 16'h0; mPre = 0; mRel = 8'h0; mSlowPend = 1'b0; mSlowAct = 1'b0;
      mEn = 1'b1; mDone = 1'b0; mRon = 1'b0; mFlag = 1'b0; mReq = 1'b0;
    end else begin
      logic tick, ovf;
      tick = mEn && (mPre == preEnd(mSlowAct));
      ovf  = tick && (mCnt == 16'hFFFF);
      mReq = ovf;
      if (ovf) begin
        mCnt = 16'h0; mPre = 0; mRel = 8'h0; mSlowPend = 1'b0; mSlowAct = 1'b0;
        mEn = 1'b1; mDone = 1'b0; mRon = 1'b0; mFlag = 1'b1;
      end else begin
        if (serviceStb) begin
          mCnt = {mRel, 8'h00}; mPre = 0; mSlowAct = mSlowPend;
        end else if (mEn) begin
          if (tick) begin mPre = 0; mCnt = mCnt + 16'd1; end
          else mPre = mPre + 1;
        end
        if (cfgWr) begin mRel = cfgReload; mSlowPend = cfgSlow; end
        if (flagClr) mFlag = 1'b0;
        if (disableStb && !mDone) mEn = 1'b0;
        if (initDoneStb) begin mDone = 1'b1; mRon = 1'b1; end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // drive one cycle of inputs, wait for the falling edge, compare against model
  task automatic step(input logic svc = 1'b0, input logic dis = 1'b0, input logic done = 1'b0,
                      input logic wr = 1'b0, input logic [7:0] rel = 8'h00,
                      input logic slow = 1'b0, input logic clr = 1'b0);
    serviceStb = svc; disableStb = dis; initDoneStb = done;
    cfgWr = wr; cfgReload = rel; cfgSlow = slow; flagClr = clr;
    @(negedge clk);
    chk("R2 count", 32'(wdtCount), 32'(mCnt));
    chk("R3 resetReq", 32'(resetReq), 32'(mReq));
    chk("R8 resetOutN", 32'(resetOutN), 32'(mRon));
    chk("R10 flag", 32'(wdtRstFlag), 32'(mFlag));
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG_CYCLES) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG_CYCLES);
      summary();
    end
  end

  initial begin
    logic [15:0] c0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk("R1 count", 32'(wdtCount), 32'h0);
    chk("R1 resetOutN", 32'(resetOutN), 32'h0);
    chk("R1 flag", 32'(wdtRstFlag), 32'h0);
    chk("R1 resetReq", 32'(resetReq), 32'h0);

    // R3: default timeout of 131072 edges
    for (int i = 1; i < 131072; i++) begin
      step();
      if (i == 4) chk("R2 div2 rate", 32'(wdtCount), 32'h2);
      if (i == 131071) chk("R3 no early req", 32'(resetReq), 32'h0);
    end
    step();
    chk("R3 req at 131072", 32'(resetReq), 32'h1);
    chk("R7 count cleared", 32'(wdtCount), 32'h0);
    chk("R7 resetOutN low", 32'(resetOutN), 32'h0);
    chk("R10 flag set", 32'(wdtRstFlag), 32'h1);
    step();
    chk("R3 req one cycle", 32'(resetReq), 32'h0);

    // R8 / R10
    step(.done(1'b1));
    chk("R8 released", 32'(resetOutN), 32'h1);
    step(.clr(1'b1));
    chk("R10 flag cleared", 32'(wdtRstFlag), 32'h0);

    // R6: disable after end of init is ignored
    step(.dis(1'b1));
    c0 = wdtCount;
    repeat (20) step();
    chk("R6 late disable ignored", 32'(wdtCount), 32'(c0 + 16'd10));

    // R5: staged write has no effect before service
    step(.wr(1'b1), .rel(8'hFF));
    step();
    chk("R5 no early reload", 32'(wdtCount[15:8]), 32'h0);
    step(.svc(1'b1));
    chk("R4 service load", 32'(wdtCount), 32'hFF00);
    repeat (510) step();
    chk("R4 reach max", 32'(wdtCount), 32'hFFFF);
    step();
    step(.svc(1'b1));
    chk("R9 overflow beats service", 32'(resetReq), 32'h1);
    chk("R9 count zero", 32'(wdtCount), 32'h0);

    // R7: config restored; window reopened so disable works
    step(.svc(1'b1));
    chk("R7 reload restored", 32'(wdtCount), 32'h0);
    step(.dis(1'b1));
    c0 = wdtCount;
    repeat (300) step();
    chk("R6 early disable holds", 32'(wdtCount), 32'(c0));
    chk("R8 still low", 32'(resetOutN), 32'h0);

    // R2: slow prescale
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    step(.wr(1'b1), .rel(8'hFF), .slow(1'b1));
    step(.svc(1'b1));
    chk("R4 load slow", 32'(wdtCount), 32'hFF00);
    repeat (127) step();
    chk("R2 slow hold", 32'(wdtCount), 32'hFF00);
    step();
    chk("R2 slow step", 32'(wdtCount), 32'hFF01);

    // random phase
    for (int i = 0; i < 20000; i++) begin
      logic rs;
      rs = ($urandom % 5000) == 0;
      if (rs) rstN = 1'b0;
      step(.svc(($urandom % 3000) == 0), .dis(($urandom % 2000) == 0),
           .done(($urandom % 1000) == 0), .wr(($urandom % 50) == 0),
           .rel(8'hF0 | 8'($urandom % 16)), .slow(($urandom % 8) == 0),
           .clr(($urandom % 500) == 0));
      if (rs) rstN = 1'b1;
    end
    summary();
  end
endmodule